// File: doc/BRIEF.md
# Multiplicative VSID Scrambler

This unit turns an effective address, or a user context number plus an effective address, into a 36-bit virtual segment identifier. It first builds an unscrambled identifier (the proto-VSID). For kernel requests this is the segment number taken from the address. For user requests it is the context number placed above a 16-bit segment number. The unit then hashes the proto-VSID by multiplying it with a fixed 28-bit prime and reducing the product modulo 2^36-1. The reduction uses no divider and no second multiplier.

The Mersenne form of the modulus allows a short reduction. The product is split at bit 36 and the two halves are added. One conditional increment then finishes the job. The increment is taken from the carry out of the folded sum plus one. The datapath is a three-stage pipeline (multiply, fold, correct) that accepts one request per cycle.

Some requests are reserved: the all-ones proto-VSID, proto-VSIDs whose top two bits are `10`, and user addresses whose segment number needs more than 16 bits. These requests come out with an error flag and a zero identifier.

Top module: `vsid_scrambler`

## Requirements
- R1: For a kernel request (`kernel_i`=1), the proto-VSID is `ea_i[63:28]`, which is the effective address shifted right by 28.
- R2: For a user request (`kernel_i`=0), the proto-VSID is `{1'b0, ctx_i[18:0], ea_i[43:28]}`, which is the context shifted left by 16 and ORed with the 16-bit segment number.
- R3: For a request without error, `vsid_o` equals (proto-VSID × 200730139) mod (2^36-1).
- R4: Each request produces exactly one result. `valid_o` is high in the cycle that follows the third rising clock edge after the request is sampled. Requests on back-to-back cycles come out on back-to-back cycles, in order.
- R5: A proto-VSID of 0xFFFFFFFFF raises `err_o` together with `valid_o`, and `vsid_o` is zero.
- R6: A proto-VSID whose two top bits (bits 35:34) are `10` raises `err_o` and gives a zero `vsid_o`.
- R7: A user request with any of `ea_i[63:44]` set raises `err_o` and gives a zero `vsid_o`.
- R8: While `rst_ni` is low, `valid_o`, `err_o` and `vsid_o` are all zero.
- R9: A valid output never carries the identifier 0xFFFFFFFFF.
- R10: While `valid_o` is low, `vsid_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| kernel_i | input | 1 | 1: kernel request, 0: user request |
| ea_i | input | 64 | Effective address |
| ctx_i | input | 19 | User context number |
| valid_o | output | 1 | Result strobe |
| vsid_o | output | 36 | Scrambled identifier |
| err_o | output | 1 | Reserved or out-of-range request |

## Verification
The bench builds the unit with its default parameters: a 36-bit identifier, a 28-bit segment shift, a 19-bit context, a 16-bit user segment field and the 28-bit prime multiplier. At these values the largest legal proto-VSID, 2^36-2, can be reached through a kernel address, and so can products whose folded sum lands at or above the modulus, which exercises the correction increment. A wide-arithmetic reference computes the remainder directly. Back-to-back random mixes of kernel and user requests, together with reserved patterns, check ordering, latency and error masking.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int unsigned EA_W_DEF      = 64;
  localparam int unsigned SID_SHIFT_DEF = 28;
  localparam int unsigned VSID_W_DEF    = 36;
  localparam int unsigned CTX_W_DEF     = 19;
  localparam int unsigned UESID_W_DEF   = 16;
  localparam int unsigned MULT_DEF      = 200730139;
  localparam int unsigned PIPE_DEPTH    = 3;
endpackage

// File: rtl/vsid_proto_form.sv
module vsid_proto_form #(
  parameter int unsigned EA_W      = 64,
  parameter int unsigned SID_SHIFT = 28,
  parameter int unsigned VSID_W    = 36,
  parameter int unsigned CTX_W     = 19,
  parameter int unsigned UESID_W   = 16
) (
  input  logic              kernel_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [VSID_W-1:0] proto_o,
  output logic              err_o
);
  localparam int unsigned KHI_LO = SID_SHIFT + VSID_W;
  localparam int unsigned UHI_LO = SID_SHIFT + UESID_W;

  logic [VSID_W-1:0] kern_proto;
  logic [VSID_W-1:0] user_proto;
  logic              kern_range_err;
  logic              user_range_err;
  logic              reserved;

  assign kern_proto = ea_i[SID_SHIFT +: VSID_W];
  assign user_proto = VSID_W'({ctx_i, ea_i[SID_SHIFT +: UESID_W]});

  // address bits above the kernel segment field
  generate
    if (EA_W > KHI_LO) begin : g_khi
      assign kern_range_err = |ea_i[EA_W-1:KHI_LO];
    end else begin : g_nokhi
      assign kern_range_err = 1'b0;
    end
    if (EA_W > UHI_LO) begin : g_uhi
      assign user_range_err = |ea_i[EA_W-1:UHI_LO];
    end else begin : g_nouhi
      assign user_range_err = 1'b0;
    end
  endgenerate

  always_comb begin
    proto_o  = kernel_i ? kern_proto : user_proto;
    reserved = (&proto_o) || (proto_o[VSID_W-1 -: 2] == 2'b10);
    err_o    = reserved || (kernel_i ? kern_range_err : user_range_err);
  end
endmodule

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage #(
  parameter int unsigned VSID_W = 36,
  parameter int unsigned MULT   = 200730139,
  parameter int unsigned MULT_W = 28,
  localparam int unsigned PROD_W = VSID_W + MULT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [VSID_W-1:0] proto_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [PROD_W-1:0] prod_o
);
  localparam logic [PROD_W-1:0] MULT_EXT = PROD_W'(MULT);

  logic [PROD_W-1:0] prod_d;
  assign prod_d = PROD_W'(proto_i) * MULT_EXT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & err_i;
      prod_o  <= prod_d;
    end
  end
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage #(
  parameter int unsigned VSID_W = 36,
  parameter int unsigned MULT_W = 28,
  localparam int unsigned PROD_W = VSID_W + MULT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [VSID_W:0]   fold_o
);
  logic [VSID_W:0] fold_d;

  // 2^36 == 1 mod (2^36-1): upper half weighs the same as the lower
  assign fold_d = {1'b0, prod_i[VSID_W-1:0]} + (VSID_W+1)'(prod_i[PROD_W-1:VSID_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      fold_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & err_i;
      fold_o  <= fold_d;
    end
  end
endmodule

// File: rtl/vsid_correct_stage.sv
module vsid_correct_stage #(
  parameter int unsigned VSID_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              err_i,
  input  logic [VSID_W:0]   fold_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [VSID_W-1:0] vsid_o
);
  logic [VSID_W:0]   fold_inc;
  logic [VSID_W:0]   fixed;
  logic [VSID_W-1:0] vsid_d;

  // fold < 2*(2^36-1), so one carry-driven +1 completes the reduction
  always_comb begin
    fold_inc = fold_i + (VSID_W+1)'(1);
    fixed    = fold_i + (VSID_W+1)'(fold_inc[VSID_W]);
    vsid_d   = (valid_i && !err_i) ? fixed[VSID_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      vsid_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & err_i;
      vsid_o  <= vsid_d;
    end
  end
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler #(
  parameter int unsigned EA_W      = vsid_pkg::EA_W_DEF,
  parameter int unsigned SID_SHIFT = vsid_pkg::SID_SHIFT_DEF,
  parameter int unsigned VSID_W    = vsid_pkg::VSID_W_DEF,
  parameter int unsigned CTX_W     = vsid_pkg::CTX_W_DEF,
  parameter int unsigned UESID_W   = vsid_pkg::UESID_W_DEF,
  parameter int unsigned MULT      = vsid_pkg::MULT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              kernel_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              valid_o,
  output logic [VSID_W-1:0] vsid_o,
  output logic              err_o
);
  localparam int unsigned MULT_W = $clog2(MULT + 1);
  localparam int unsigned PROD_W = VSID_W + MULT_W;

  logic [VSID_W-1:0] proto;
  logic              form_err;
  logic              s1_valid, s1_err;
  logic [PROD_W-1:0] s1_prod;
  logic              s2_valid, s2_err;
  logic [VSID_W:0]   s2_fold;

  vsid_proto_form #(
    .EA_W(EA_W), .SID_SHIFT(SID_SHIFT), .VSID_W(VSID_W),
    .CTX_W(CTX_W), .UESID_W(UESID_W)
  ) u_form (
    .kernel_i(kernel_i), .ea_i(ea_i), .ctx_i(ctx_i),
    .proto_o(proto), .err_o(form_err)
  );

  vsid_mul_stage #(.VSID_W(VSID_W), .MULT(MULT), .MULT_W(MULT_W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(valid_i), .err_i(form_err), .proto_i(proto),
    .valid_o(s1_valid), .err_o(s1_err), .prod_o(s1_prod)
  );

  vsid_fold_stage #(.VSID_W(VSID_W), .MULT_W(MULT_W)) u_fold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(s1_valid), .err_i(s1_err), .prod_i(s1_prod),
    .valid_o(s2_valid), .err_o(s2_err), .fold_o(s2_fold)
  );

  vsid_correct_stage #(.VSID_W(VSID_W)) u_corr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(s2_valid), .err_i(s2_err), .fold_i(s2_fold),
    .valid_o(valid_o), .err_o(err_o), .vsid_o(vsid_o)
  );
endmodule

// File: rtl/vsid_scrambler_chk.sv
module vsid_scrambler_chk #(
  parameter int unsigned EA_W      = 64,
  parameter int unsigned SID_SHIFT = 28,
  parameter int unsigned VSID_W    = 36,
  parameter int unsigned CTX_W     = 19,
  parameter int unsigned UESID_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              kernel_i,
  input logic [EA_W-1:0]   ea_i,
  input logic [CTX_W-1:0]  ctx_i,
  input logic              valid_o,
  input logic [VSID_W-1:0] vsid_o,
  input logic              err_o
);
  logic [1:0] since_rst;
  logic       ones_in;
  logic       user_wide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign ones_in   = valid_i && kernel_i && (&ea_i[SID_SHIFT +: VSID_W]);
  assign user_wide = valid_i && !kernel_i && (|ea_i[EA_W-1:SID_SHIFT+UESID_W]);

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  // R5
  all_ones_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(ones_in, 3)) |-> (err_o && vsid_o == '0));

  // R7
  user_range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(user_wide, 3)) |-> (err_o && vsid_o == '0));

  // R9
  no_reserved_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(&vsid_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (vsid_o == '0 && !err_o));

  // R5
  err_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (valid_o && vsid_o == '0));
endmodule

bind vsid_scrambler vsid_scrambler_chk #(
  .EA_W(EA_W), .SID_SHIFT(SID_SHIFT), .VSID_W(VSID_W),
  .CTX_W(CTX_W), .UESID_W(UESID_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .kernel_i(kernel_i),
  .ea_i(ea_i), .ctx_i(ctx_i), .valid_o(valid_o), .vsid_o(vsid_o), .err_o(err_o)
);

// File: tb/vsid_scrambler_bench.sv
module vsid_scrambler_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] MULT_M = 128'd200730139;
  localparam logic [127:0] MODV   = (128'd1 << 36) - 128'd1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        kernel_i = 1'b0;
  logic [63:0] ea_i = '0;
  logic [18:0] ctx_i = '0;
  logic        valid_o;
  logic [35:0] vsid_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [35:0] vsid;
    logic        err;
    string       req;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vsid_scrambler u_vsid_scrambler (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .kernel_i(kernel_i),
    .ea_i(ea_i), .ctx_i(ctx_i), .valid_o(valid_o), .vsid_o(vsid_o), .err_o(err_o)
  );

  function automatic logic [35:0] ref_scramble(input logic [35:0] p);
    logic [127:0] w;
    w = (128'(p) * MULT_M) % MODV;
    return w[35:0];
  endfunction

  function automatic exp_t model(input logic k, input logic [63:0] ea,
                                 input logic [18:0] ctx, input string req);
    exp_t e;
    logic [35:0] p;
    logic bad;
    if (k) begin
      p   = ea[63:28];
      bad = (&p) || (p[35:34] == 2'b10);
    end else begin
      p   = {1'b0, ctx, ea[43:28]};
      bad = |ea[63:44];
    end
    e.err  = bad;
    e.vsid = bad ? 36'd0 : ref_scramble(p);
    e.req  = req;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4", "unexpected valid_o", 64'(vsid_o), 64'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(vsid_o == e.vsid, e.req, "vsid_o", 64'(vsid_o), 64'(e.vsid));
        check(err_o == e.err, e.req, "err_o", 64'(err_o), 64'(e.err));
      end
    end
  end

  task automatic send(input logic k, input logic [63:0] ea,
                      input logic [18:0] ctx, input string req);
    @(negedge clk);
    valid_i  = 1'b1;
    kernel_i = k;
    ea_i     = ea;
    ctx_i    = ctx;
    expq.push_back(model(k, ea, ctx, req));
  endtask

  task automatic idle_drain();
    @(negedge clk);
    valid_i = 1'b0;
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R4", "results outstanding", 64'(expq.size()), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R8", "valid_o in reset", 64'(valid_o), 64'd0);
    check(vsid_o == '0, "R8", "vsid_o in reset", 64'(vsid_o), 64'd0);
    check(err_o == 1'b0, "R8", "err_o in reset", 64'(err_o), 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_kernel();
    send(1'b1, 64'hC000_0000_0000_0000, '0, "R1");
    send(1'b1, 64'hC000_0000_1234_5678, '0, "R1");
    send(1'b1, 64'hFFFF_FFFE_0000_0000, '0, "R3");
    send(1'b1, 64'h0000_0000_1000_0000, '0, "R3");
    send(1'b1, 64'h0000_0000_0FFF_FFFF, '0, "R3");
    send(1'b1, 64'hFFFF_FFFE_ABCD_EF01, '0, "R9");
    idle_drain();
  endtask

  task automatic t_user();
    send(1'b0, 64'h0000_0000_1000_0000, 19'd1, "R2");
    send(1'b0, 64'h0000_0FFF_F000_0000, 19'h7FFFF, "R2");
    send(1'b0, 64'h0000_0123_4567_89AB, 19'h2A5A5, "R2");
    send(1'b0, 64'h0000_0000_0000_0000, 19'd0, "R2");
    idle_drain();
  endtask

  task automatic t_reserved();
    send(1'b1, 64'hFFFF_FFFF_F000_0000, '0, "R5");
    send(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R5");
    send(1'b1, 64'h8000_0000_0000_0000, '0, "R6");
    send(1'b1, 64'hBFFF_FFFF_F000_0000, '0, "R6");
    send(1'b0, 64'h0000_1000_0000_0000, 19'd5, "R7");
    send(1'b0, 64'hC000_0000_0000_0000, 19'd5, "R7");
    send(1'b1, 64'hC000_0000_0000_0000, '0, "R1");
    idle_drain();
  endtask

  task automatic t_latency();
    int lat;
    @(negedge clk);
    valid_i  = 1'b1;
    kernel_i = 1'b1;
    ea_i     = 64'hD000_0000_7000_0000;
    expq.push_back(model(1'b1, ea_i, '0, "R4"));
    lat = 0;
    @(negedge clk);
    valid_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 10) begin
      check(vsid_o == '0 && err_o == 1'b0, "R10", "outputs while idle",
            64'({err_o, vsid_o}), 64'd0);
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R4", "latency", 64'(lat), 64'd3);
    idle_drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) begin
      logic k;
      logic [63:0] ea;
      k  = 1'($urandom());
      ea = {$urandom(), $urandom()};
      if (!k && (i % 4 != 0)) ea[63:44] = '0;
      send(k, ea, 19'($urandom()), "R4");
    end
    idle_drain();
  endtask

  initial begin
    t_reset();
    t_kernel();
    t_user();
    t_reserved();
    t_latency();
    t_stream();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule